// File: doc/BRIEF.md
# USB2 PHY Power-Up Reset Sequencer

This block brings a two-port USB2 PHY out of reset in a fixed order from one init request, and takes it back down on an exit request. On init it turns on the reference clock and releases the power-on reset. It then sends one configuration write that switches on the PHY's internal clock, and finally releases the UTMI reset of the selected port. A settle time separates each step, and every settle time is counted in system-clock cycles derived from a `CLK_HZ` parameter. Exit works in the opposite direction and steps one clock per stage.

The configuration write leaves on a valid/ready stream towards a test-port writer. `cfg_valid` rises once per init and stays high, with a constant payload, until the cycle in which `cfg_ready` is also high. That cycle is the handshake. The writer may stall for any number of cycles, and the sequencer waits for it. Requests, port select and status are plain level pins.

Top module: `phy_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `refclk_en`, `por_n`, every bit of `utmi_rst_n`, `cfg_valid`, `busy` and `done` are all 0.
- R2: An init accepted at edge E0 sets `refclk_en` at E0. `por_n` rises at edge E0+REF_CYC, where REF_CYC is the 100 µs delay.
- R3: `cfg_valid` rises POR_CYC edges (300 µs) after `por_n` rises. The payload is `cfg_port`=0, `cfg_addr`=0x06 and `cfg_data`=0x04, which is bit 2 set.
- R4: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high, the payload stays unchanged and the sequence does not advance. `cfg_valid` falls after the handshake edge.
- R5: `utmi_rst_n[port]` rises PHY_CYC edges (2 ms) after the handshake edge. The other port's bit is left unchanged.
- R6: `done` pulses for one cycle UTMI_CYC edges (2 ms) after the UTMI release. `busy` is high from the cycle after acceptance until `done` rises, and is low whenever `done` is high.
- R7: An init for a second port, issued while the power-on reset is already released, runs the full order with the same delays. `refclk_en` and `por_n` stay high throughout.
- R8: An exit accepted at edge E0 clears `utmi_rst_n[port]` at E0. At E0+1 it clears `por_n` together with every UTMI reset bit. At E0+2 it clears `refclk_en` and pulses `done`.
- R9: `init_req` and `exit_req` have no effect while `busy` is high.
- R10: Each delay is ceil(CLK_HZ × µs / 10^6) cycles, with a minimum of 1.
- R11: If `init_req` and `exit_req` are both high while idle, the init is taken and the exit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the bring-up of `port_sel` |
| exit_req | input | 1 | Start the shutdown of `port_sel` |
| port_sel | input | PORT_W | Port addressed by a request |
| refclk_en | output | 1 | Reference clock enable |
| por_n | output | 1 | Active-low power-on reset |
| utmi_rst_n | output | NUM_PORTS | Active-low UTMI reset, one per port |
| cfg_valid | output | 1 | Configuration write valid |
| cfg_ready | input | 1 | Configuration write accepted |
| cfg_port | output | CFG_PORT_W | Configuration target port |
| cfg_addr | output | CFG_ADDR_W | Configuration register address |
| cfg_data | output | CFG_DATA_W | Configuration write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume that `cfg_ready` is only a response: raising it never creates a handshake by itself. They also assume that requests arrive from a clean idle, not in the cycle when `rst_n` releases. The stimulus changes every input at the falling edge. It raises `cfg_ready` only after `cfg_valid` has been seen, and it drives requests only after reset has settled. Requests made during a busy sequence are injected on purpose, to show that they are ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF_WAIT,
    ST_POR_WAIT,
    ST_CFG,
    ST_PHY_WAIT,
    ST_UTMI_WAIT,
    ST_EX_POR,
    ST_EX_REF
  } seq_state_e;

  // Rounded-up cycle count for a delay in microseconds, never below one.
  function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                   longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/utmi_rst_bank.sv
module utmi_rst_bank #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rel_en,
  input  logic [PORT_W-1:0]    rel_sel,
  input  logic                 clr_one_en,
  input  logic [PORT_W-1:0]    clr_sel,
  input  logic                 clr_all,
  output logic [NUM_PORTS-1:0] rst_n_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       rst_n_o[p] <= 1'b0;
      else if (clr_all)                                 rst_n_o[p] <= 1'b0;
      else if (clr_one_en && (clr_sel == PORT_W'(p)))   rst_n_o[p] <= 1'b0;
      else if (rel_en && (rel_sel == PORT_W'(p)))       rst_n_o[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_source.sv
module cfg_source #(
  parameter int              PORT_W  = 3,
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 8,
  parameter logic [PORT_W-1:0] TGT_PORT = '0,
  parameter logic [ADDR_W-1:0] TGT_ADDR = 8'h06,
  parameter logic [DATA_W-1:0] TGT_DATA = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ready,
  output logic              valid,
  output logic              fire,
  output logic [PORT_W-1:0] port_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              valid <= 1'b0;
    else if (start)          valid <= 1'b1;
    else if (valid && ready) valid <= 1'b0;
  end

  assign fire   = valid && ready;
  assign port_o = TGT_PORT;
  assign addr_o = TGT_ADDR;
  assign data_o = TGT_DATA;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid); // R4
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter int              NUM_PORTS  = 2,
  parameter int              REF_US     = 100,
  parameter int              POR_US     = 300,
  parameter int              PHY_US     = 2000,
  parameter int              UTMI_US    = 2000,
  parameter int              CFG_PORT_W = 3,
  parameter int              CFG_ADDR_W = 8,
  parameter int              CFG_DATA_W = 8,
  localparam int             PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_req,
  input  logic                  exit_req,
  input  logic [PORT_W-1:0]     port_sel,
  output logic                  refclk_en,
  output logic                  por_n,
  output logic [NUM_PORTS-1:0]  utmi_rst_n,
  output logic                  cfg_valid,
  input  logic                  cfg_ready,
  output logic [CFG_PORT_W-1:0] cfg_port,
  output logic [CFG_ADDR_W-1:0] cfg_addr,
  output logic [CFG_DATA_W-1:0] cfg_data,
  output logic                  busy,
  output logic                  done
);
  localparam longint unsigned REF_CYC  = us_to_cycles(CLK_HZ, REF_US);
  localparam longint unsigned POR_CYC  = us_to_cycles(CLK_HZ, POR_US);
  localparam longint unsigned PHY_CYC  = us_to_cycles(CLK_HZ, PHY_US);
  localparam longint unsigned UTMI_CYC = us_to_cycles(CLK_HZ, UTMI_US);
  localparam longint unsigned MAX_A = (REF_CYC > POR_CYC) ? REF_CYC : POR_CYC;
  localparam longint unsigned MAX_B = (PHY_CYC > UTMI_CYC) ? PHY_CYC : UTMI_CYC;
  localparam longint unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  seq_state_e state_q;
  logic [PORT_W-1:0] tgt_q;

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             cfg_start, cfg_fire;
  logic             utmi_rel, utmi_clr_one, utmi_clr_all;

  seq_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  utmi_rst_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_utmi (
    .clk(clk), .rst_n(rst_n),
    .rel_en(utmi_rel), .rel_sel(tgt_q),
    .clr_one_en(utmi_clr_one), .clr_sel(port_sel),
    .clr_all(utmi_clr_all), .rst_n_o(utmi_rst_n)
  );

  cfg_source #(
    .PORT_W(CFG_PORT_W), .ADDR_W(CFG_ADDR_W), .DATA_W(CFG_DATA_W),
    .TGT_PORT('0), .TGT_ADDR(CFG_ADDR_W'(8'h06)), .TGT_DATA(CFG_DATA_W'(8'h04))
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(cfg_start), .ready(cfg_ready),
    .valid(cfg_valid), .fire(cfg_fire),
    .port_o(cfg_port), .addr_o(cfg_addr), .data_o(cfg_data)
  );

  // Step decode: timer loads, handshake start and UTMI reset strobes.
  always_comb begin
    tmr_load     = 1'b0;
    tmr_val      = '0;
    cfg_start    = 1'b0;
    utmi_rel     = 1'b0;
    utmi_clr_one = 1'b0;
    utmi_clr_all = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (init_req) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(REF_CYC - 1);
        end else if (exit_req) begin
          utmi_clr_one = 1'b1;
        end
      end
      ST_REF_WAIT: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(POR_CYC - 1);
      end
      ST_POR_WAIT: if (tmr_exp) cfg_start = 1'b1;
      ST_CFG: if (cfg_fire) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PHY_CYC - 1);
      end
      ST_PHY_WAIT: if (tmr_exp) begin
        utmi_rel = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(UTMI_CYC - 1);
      end
      ST_EX_POR: utmi_clr_all = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      refclk_en <= 1'b0;
      por_n     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (init_req) begin
            tgt_q     <= port_sel;
            refclk_en <= 1'b1;
            state_q   <= ST_REF_WAIT;
          end else if (exit_req) begin
            tgt_q   <= port_sel;
            state_q <= ST_EX_POR;
          end
        end
        ST_REF_WAIT: if (tmr_exp) begin
          por_n   <= 1'b1;
          state_q <= ST_POR_WAIT;
        end
        ST_POR_WAIT:  if (tmr_exp)  state_q <= ST_CFG;
        ST_CFG:       if (cfg_fire) state_q <= ST_PHY_WAIT;
        ST_PHY_WAIT:  if (tmr_exp)  state_q <= ST_UTMI_WAIT;
        ST_UTMI_WAIT: if (tmr_exp) begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_EX_POR: begin
          por_n   <= 1'b0;
          state_q <= ST_EX_REF;
        end
        ST_EX_REF: begin
          refclk_en <= 1'b0;
          done      <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_POR_NEEDS_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
    por_n |-> refclk_en); // R2
  AST_POR_RISE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> $past(refclk_en)); // R2
  AST_CFG_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> por_n && refclk_en); // R3
  AST_UTMI_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (|utmi_rst_n) |-> por_n); // R8
  AST_REF_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refclk_en) |-> !por_n && $past(!por_n)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_BUSY_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    busy && refclk_en && !(state_q == ST_EX_REF) |=> refclk_en); // R9
endmodule

// File: tb/phy_bringup_seq_tb_top.sv
module phy_bringup_seq_tb_top;
  localparam longint unsigned HZ_A = 1_000_000;
  localparam longint unsigned HZ_B = 1_500;

  function automatic int cyc(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us + 999999) / 1000000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int REF_A = 100, POR_A = 300, PHY_A = 2000, UTMI_A = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic init_req = 0, exit_req = 0, cfg_ready = 0;
  logic [0:0] port_sel = '0;
  logic refclk_en, por_n, cfg_valid, busy, done;
  logic [1:0] utmi_rst_n;
  logic [2:0] cfg_port;
  logic [7:0] cfg_addr, cfg_data;

  phy_bringup_seq #(.CLK_HZ(HZ_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
    .port_sel(port_sel), .refclk_en(refclk_en), .por_n(por_n),
    .utmi_rst_n(utmi_rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_port(cfg_port), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .busy(busy), .done(done)
  );

  logic b_init = 0;
  logic b_ref, b_por, b_valid, b_busy, b_done;
  logic [1:0] b_utmi;
  logic [2:0] b_port;
  logic [7:0] b_addr, b_data;

  phy_bringup_seq #(.CLK_HZ(HZ_B)) dut_slow_i (
    .clk(clk), .rst_n(rst_n), .init_req(b_init), .exit_req(1'b0),
    .port_sel(1'b0), .refclk_en(b_ref), .por_n(b_por),
    .utmi_rst_n(b_utmi), .cfg_valid(b_valid), .cfg_ready(1'b1),
    .cfg_port(b_port), .cfg_addr(b_addr), .cfg_data(b_data),
    .busy(b_busy), .done(b_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_init(input int p, input bit por_pre, input int hold, input bit both);
    logic other;
    other = utmi_rst_n[1-p];
    port_sel = 1'(p); init_req = 1; exit_req = both;
    step(1);
    init_req = 0; exit_req = 0;
    chk(refclk_en == 1, "R2 refclk on accept", refclk_en, 1);
    chk(busy == 1, "R6 busy after accept", busy, 1);
    step(REF_A - 1);
    chk(por_n == por_pre, "R2/R7 por before ref delay", por_n, por_pre);
    step(1);
    chk(por_n == 1, "R2 por released", por_n, 1);
    step(POR_A - 1);
    chk(cfg_valid == 0, "R3 valid early", cfg_valid, 0);
    step(1);
    chk(cfg_valid == 1, "R3 valid at por delay", cfg_valid, 1);
    chk({cfg_port, cfg_addr, cfg_data} == {3'd0, 8'h06, 8'h04}, "R3 payload",
        {cfg_port, cfg_addr, cfg_data}, {3'd0, 8'h06, 8'h04});
    for (int i = 0; i < hold; i++) begin
      step(1);
      chk(cfg_valid == 1 && cfg_addr == 8'h06 && cfg_data == 8'h04, "R4 hold under stall",
          cfg_valid, 1);
    end
    cfg_ready = 1;
    step(1);
    cfg_ready = 0;
    chk(cfg_valid == 0, "R4 valid drops after handshake", cfg_valid, 0);
    step(5);
    port_sel = 1'(1 - p); init_req = 1; exit_req = 1;
    step(1);
    init_req = 0; exit_req = 0; port_sel = 1'(p);
    step(PHY_A - 1 - 6);
    chk(utmi_rst_n[p] == 0, "R5 utmi held before phy delay", utmi_rst_n[p], 0);
    chk(por_n == 1 && refclk_en == 1, "R9 busy request ignored", {refclk_en, por_n}, 3);
    step(1);
    chk(utmi_rst_n[p] == 1, "R5 utmi released", utmi_rst_n[p], 1);
    chk(utmi_rst_n[1-p] == other, "R5 other port unchanged", utmi_rst_n[1-p], other);
    step(UTMI_A - 1);
    chk(done == 0 && busy == 1, "R6 not done early", {done, busy}, 1);
    step(1);
    chk(done == 1 && busy == 0, "R6 done pulse", {done, busy}, 2);
    step(1);
    chk(done == 0, "R6 done one cycle", done, 0);
    chk(refclk_en == 1 && por_n == 1 && cfg_valid == 0, "R7 state after init",
        {refclk_en, por_n, cfg_valid}, 6);
  endtask

  task automatic do_exit(input int p);
    logic other;
    other = utmi_rst_n[1-p];
    port_sel = 1'(p); exit_req = 1;
    step(1);
    exit_req = 0;
    chk(utmi_rst_n[p] == 0 && utmi_rst_n[1-p] == other, "R8 own utmi first",
        utmi_rst_n, {other, 1'b0});
    chk(por_n == 1 && refclk_en == 1 && busy == 1, "R8 por still released",
        {por_n, refclk_en, busy}, 7);
    step(1);
    chk(por_n == 0 && utmi_rst_n == 2'b00 && refclk_en == 1, "R8 por second",
        {por_n, utmi_rst_n, refclk_en}, 1);
    step(1);
    chk(refclk_en == 0 && done == 1 && busy == 0, "R8 refclk last", {refclk_en, done, busy}, 2);
    step(1);
    chk(done == 0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t_por, t_val, t_utmi, t_done;
    int e_ref, e_por, e_phy, e_utmi;
    step(3);
    chk({refclk_en, por_n, utmi_rst_n, cfg_valid, busy, done} == 0, "R1 in reset",
        {refclk_en, por_n, utmi_rst_n, cfg_valid, busy, done}, 0);
    rst_n = 1;
    step(1);
    chk({refclk_en, por_n, utmi_rst_n, cfg_valid, busy, done} == 0, "R1 after reset",
        {refclk_en, por_n, utmi_rst_n, cfg_valid, busy, done}, 0);
    step(2);

    do_init(0, 1'b0, 3, 1'b0);
    do_init(1, 1'b1, 0, 1'b0);   // R7 second port, full order
    do_exit(1);
    do_init(0, 1'b0, 1, 1'b1);   // R11 init wins over simultaneous exit
    do_exit(0);

    // R10 rounded delays on the low-frequency instance
    e_ref = cyc(HZ_B, 100); e_por = cyc(HZ_B, 300);
    e_phy = cyc(HZ_B, 2000); e_utmi = cyc(HZ_B, 2000);
    t_por = -1; t_val = -1; t_utmi = -1; t_done = -1;
    b_init = 1;
    step(1);
    b_init = 0;
    chk(b_ref == 1, "R10 slow refclk", b_ref, 1);
    for (int t = 1; t <= 40; t++) begin
      step(1);
      if (b_por && t_por < 0) t_por = t;
      if (b_valid && t_val < 0) t_val = t;
      if (b_utmi[0] && t_utmi < 0) t_utmi = t;
      if (b_done && t_done < 0) t_done = t;
    end
    chk(t_por == e_ref, "R10 ref delay", t_por, e_ref);
    chk(t_val == e_ref + e_por, "R10 por delay", t_val, e_ref + e_por);
    chk(t_utmi == e_ref + e_por + 1 + e_phy, "R10 phy delay", t_utmi, e_ref + e_por + 1 + e_phy);
    chk(t_done == t_utmi + e_utmi, "R10 utmi delay", t_done, t_utmi + e_utmi);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule